// File: doc/BRIEF.md
# External Bus Byte-Lane Strobe Generator

This block turns accesses from an internal bus into the control strobes for one external memory region with a 16-bit data bus. A requester presents an address, a direction, a size (one byte or a half-word) and write data. The block runs a fixed access sequence on the external pins and reports completion with a one-cycle done pulse. For a read, the returned data appears at the same time as that pulse.

One configuration input chooses how four control pins behave. In lane-write style, the two write pins are separate strobes for the upper and lower byte, and a single read strobe serves every read. In lane-select style, the same pins become two byte-select lines plus one direction-neutral write enable, and the read pin acts as an output enable. The external address drops internal bit 0 because each external location holds 16 bits. Write data is driven onto the bus only during the strobe phase of a write. At all other times the bus is left floating so that the memory can drive it.

Top module: `ext16_lane_strobe`

## Requirements
- R1: After reset and whenever no access is in progress, `extCsN`, `extPinA0Lb`, `extPinWrHi`, `extPinWrLo` and `extRdN` are all 1, and `busy` and `done` are 0.
- R2: A request is taken on a clock edge where `reqValid` is 1 and `busy` is 0. The access then runs through three phases: one setup cycle with `extCsN` at 0 and all strobes at 1; a strobe phase of `cfgStrobeLen`+1 cycles (so 1 to 8 cycles); and one hold cycle with strobes at 1, `extCsN` at 0 and `done` at 1. `busy` is 1 from the setup cycle through the hold cycle.
- R3: For the whole access, `extAddr` equals `reqAddr[19:1]`, the request address shifted right by one bit.
- R4: Lane-write style (`cfgByteSelect`=0) controls the write pins and holds the lower-select pin inactive:
  - `extPinA0Lb` stays at 1.
  - `extPinWrHi` goes to 0 during the strobe phase only for writes that touch bits 15:8. Those are half-word writes, and byte writes with `reqAddr[0]`=1.
  - `extPinWrLo` goes to 0 during the strobe phase only for writes that touch bits 7:0. Those are half-word writes, and byte writes with `reqAddr[0]`=0.
- R5: In lane-write style, `extRdN` goes to 0 during the strobe phase of every read, for both byte and half-word reads, and both write pins stay at 1.
- R6: Lane-select style (`cfgByteSelect`=1) uses the four pins as follows during the strobe phase:
  - `extPinA0Lb` is the lower byte select and goes to 0 when the access touches bits 7:0.
  - `extPinWrHi` is the upper byte select and goes to 0 when the access touches bits 15:8.
  - `extPinWrLo` is a write enable and goes to 0 for every write.
  - `extRdN` goes to 0 for every read.
- R7: During the strobe phase of a write, `extData` carries the write data. A half-word write places `reqWdata` on the bus as it is. A byte write places `reqWdata[7:0]` on both byte lanes.
- R8: A read captures `extData` in the last strobe cycle and holds the result on `rdData` from the hold cycle until the next read:
  - A half-word read returns all 16 bits.
  - A byte read returns the lane chosen by `reqAddr[0]` in bits 7:0 (0 selects bits 7:0, 1 selects bits 15:8), with bits 15:8 set to 0.
- R9: Request fields are captured when the request is taken, so changing them during an access has no effect on that access. A request that stays on `reqValid` while `busy` is 1 is not lost: it is taken on the edge after the idle cycle that follows the hold cycle.
- R10: `cfgByteSelect` and `cfgStrobeLen` are sampled when the request is taken. Changing them during an access does not alter that access's pins or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; held by the requester until taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqHalf | input | 1 | 1 = half-word access, 0 = byte access |
| reqAddr | input | 20 | Internal byte address |
| reqWdata | input | 16 | Write data; a byte uses bits 7:0 |
| cfgByteSelect | input | 1 | 0 = lane-write style, 1 = lane-select style |
| cfgStrobeLen | input | 3 | Strobe phase length minus one |
| busy | output | 1 | Access in progress, new requests held off |
| done | output | 1 | One-cycle pulse in the hold cycle |
| rdData | output | 16 | Read result |
| extCsN | output | 1 | Chip select, active low |
| extAddr | output | 19 | External half-word address |
| extPinA0Lb | output | 1 | Lower byte select in lane-select style, held at 1 otherwise |
| extPinWrHi | output | 1 | Upper write strobe or upper byte select, active low |
| extPinWrLo | output | 1 | Lower write strobe or write enable, active low |
| extRdN | output | 1 | Read strobe / output enable, active low |
| extData | inout | 16 | External data bus |

## Verification
The bench runs every combination of style, direction, size and lane at several strobe lengths, including both extremes. A design that swaps the lane decode would fire the wrong write pin, or return the wrong byte of an odd-address read. Two faults would show up on a lane-write read: driving the lower select pin in lane-write style, and pulsing write pins during a read. A strobe counter off by one shows as one cycle too many or too few at length 1 or length 8. The bench also changes the request fields and the configuration in the middle of an access, with `reqValid` held. A design that reads these live, rather than capturing them when the request is taken, would change the address, pins or data part-way through the access, or would drop the waiting request.

// File: rtl/ext16_lane_pkg.sv
package ext16_lane_pkg;
  localparam int BUS_W  = 16;
  localparam int LANE_W = BUS_W / 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } laneState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // take request fields this edge
    logic active;   // chip select phase (setup, strobe, hold)
    logic strobe;   // strobe phase
    logic capture;  // last strobe cycle, sample read data
  } laneCtrl_t;
endpackage

// File: rtl/lane_seq.sv
module lane_seq
  import ext16_lane_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] cfgStrobeLen,
  output laneCtrl_t        ctrl,
  output logic             busy,
  output logic             done
);
  laneState_t      state;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_SETUP;
          cnt   <= cfgStrobeLen;
        end
        ST_SETUP:  state <= ST_STROBE;
        ST_STROBE: begin
          if (cnt == '0) state <= ST_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load    = (state == ST_IDLE) && reqValid;
    ctrl.active  = (state != ST_IDLE);
    ctrl.strobe  = (state == ST_STROBE);
    ctrl.capture = (state == ST_STROBE) && (cnt == '0);
    busy         = (state != ST_IDLE);
    done         = (state == ST_HOLD);
  end
endmodule

// File: rtl/lane_path.sv
module lane_path
  import ext16_lane_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtrl_t         ctrl,
  input  logic              reqWrite,
  input  logic              reqHalf,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic              cfgByteSelect,
  output logic [BUS_W-1:0]  rdData,
  output logic              latByteSel,
  output logic              extCsN,
  output logic [ADDR_W-2:0] extAddr,
  output logic              extPinA0Lb,
  output logic              extPinWrHi,
  output logic              extPinWrLo,
  output logic              extRdN,
  inout  wire  [BUS_W-1:0]  extData
);
  logic              latWrite, latHalf;
  logic [ADDR_W-1:0] latAddr;
  logic [BUS_W-1:0]  latWdata;
  logic              touchLo, touchHi, wrStb, rdStb;
  logic [BUS_W-1:0]  busWord;
  logic [LANE_W-1:0] pickLane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latWrite   <= 1'b0;
      latHalf    <= 1'b0;
      latAddr    <= '0;
      latWdata   <= '0;
      latByteSel <= 1'b0;
    end else if (ctrl.load) begin
      latWrite   <= reqWrite;
      latHalf    <= reqHalf;
      latAddr    <= reqAddr;
      latWdata   <= reqWdata;
      latByteSel <= cfgByteSelect;
    end
  end

  // lane decode: address bit 0 picks the byte lane of a byte access
  always_comb begin
    touchLo  = latHalf || !latAddr[0];
    touchHi  = latHalf ||  latAddr[0];
    wrStb    = ctrl.strobe &&  latWrite;
    rdStb    = ctrl.strobe && !latWrite;
    busWord  = latHalf ? latWdata : {2{latWdata[LANE_W-1:0]}};
    pickLane = latAddr[0] ? extData[BUS_W-1:LANE_W] : extData[LANE_W-1:0];
  end

  always_comb begin
    extCsN  = !ctrl.active;
    extAddr = latAddr[ADDR_W-1:1];
    extRdN  = !rdStb;
    if (latByteSel) begin
      extPinA0Lb = !(ctrl.strobe && touchLo);
      extPinWrHi = !(ctrl.strobe && touchHi);
      extPinWrLo = !wrStb;
    end else begin
      extPinA0Lb = 1'b1;
      extPinWrHi = !(wrStb && touchHi);
      extPinWrLo = !(wrStb && touchLo);
    end
  end

  assign extData = wrStb ? busWord : {BUS_W{1'bz}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctrl.capture && !latWrite) begin
      rdData <= latHalf ? extData : {{(BUS_W-LANE_W){1'b0}}, pickLane};
    end
  end
endmodule

// File: rtl/ext16_lane_strobe.sv
module ext16_lane_strobe
  import ext16_lane_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqHalf,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic              cfgByteSelect,
  input  logic [LEN_W-1:0]  cfgStrobeLen,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdData,
  output logic              extCsN,
  output logic [ADDR_W-2:0] extAddr,
  output logic              extPinA0Lb,
  output logic              extPinWrHi,
  output logic              extPinWrLo,
  output logic              extRdN,
  inout  wire  [15:0]       extData
);
  laneCtrl_t ctrl;
  logic      latByteSel;

  lane_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgStrobeLen(cfgStrobeLen),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  lane_path #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqWrite(reqWrite), .reqHalf(reqHalf), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .cfgByteSelect(cfgByteSelect),
    .rdData(rdData), .latByteSel(latByteSel),
    .extCsN(extCsN), .extAddr(extAddr), .extPinA0Lb(extPinA0Lb),
    .extPinWrHi(extPinWrHi), .extPinWrLo(extPinWrLo), .extRdN(extRdN),
    .extData(extData)
  );
endmodule

// File: rtl/ext16_lane_strobe_chk.sv
module ext16_lane_strobe_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              extCsN,
  input logic [ADDR_W-2:0] extAddr,
  input logic              extPinA0Lb,
  input logic              extPinWrHi,
  input logic              extPinWrLo,
  input logic              extRdN,
  input logic              latByteSel
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (extCsN && extPinA0Lb && extPinWrHi && extPinWrLo && extRdN)); // R1
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    (!extRdN || !extPinWrHi || !extPinWrLo) |-> !extCsN); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !extCsN && extPinA0Lb && extPinWrHi && extPinWrLo && extRdN)); // R2
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!extCsN && $past(!extCsN)) |-> $stable(extAddr)); // R3
  AST_LB_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    !latByteSel |-> extPinA0Lb); // R4
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!latByteSel && !extRdN) |-> (extPinWrHi && extPinWrLo)); // R5
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    latByteSel |-> !(!extRdN && !extPinWrLo)); // R6
endmodule

bind ext16_lane_strobe ext16_lane_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .extCsN(extCsN),
  .extAddr(extAddr), .extPinA0Lb(extPinA0Lb), .extPinWrHi(extPinWrHi),
  .extPinWrLo(extPinWrLo), .extRdN(extRdN), .latByteSel(latByteSel)
);

// File: tb/ext16_lane_strobe_test.sv
`timescale 1ns/1ps
module ext16_lane_strobe_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqHalf = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        cfgByteSelect = 1'b0;
  logic [2:0]  cfgStrobeLen = '0;
  logic        busy, done;
  logic [15:0] rdData;
  logic        extCsN, extPinA0Lb, extPinWrHi, extPinWrLo, extRdN;
  logic [18:0] extAddr;
  wire  [15:0] extData;
  logic [15:0] memWord = '0;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  assign extData = (extRdN == 1'b0) ? memWord : 16'bz;

  ext16_lane_strobe uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqHalf(reqHalf), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgByteSelect(cfgByteSelect), .cfgStrobeLen(cfgStrobeLen),
    .busy(busy), .done(done), .rdData(rdData), .extCsN(extCsN),
    .extAddr(extAddr), .extPinA0Lb(extPinA0Lb), .extPinWrHi(extPinWrHi),
    .extPinWrLo(extPinWrLo), .extRdN(extRdN), .extData(extData)
  );

  // {mode, write, half, len, addr, data, pins{A0Lb,WrHi,WrLo,RdN}, result}
  typedef struct packed {
    logic        mode;
    logic        wr;
    logic        half;
    logic [2:0]  len;
    logic [19:0] addr;
    logic [15:0] data;
    logic [3:0]  pins;
    logic [15:0] res;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 3'd0, 20'h00100, 16'hA55A, 4'b1001, 16'hA55A},
    {1'b0, 1'b1, 1'b0, 3'd1, 20'h00202, 16'h123C, 4'b1101, 16'h3C3C},
    {1'b0, 1'b1, 1'b0, 3'd2, 20'h00305, 16'h00C7, 4'b1011, 16'hC7C7},
    {1'b0, 1'b0, 1'b1, 3'd3, 20'hFFFFE, 16'hBEEF, 4'b1110, 16'hBEEF},
    {1'b0, 1'b0, 1'b0, 3'd4, 20'h40001, 16'hBEEF, 4'b1110, 16'h00BE},
    {1'b1, 1'b1, 1'b1, 3'd5, 20'h0ABC0, 16'h1234, 4'b0001, 16'h1234},
    {1'b1, 1'b1, 1'b0, 3'd6, 20'h12344, 16'h0081, 4'b0101, 16'h8181},
    {1'b1, 1'b1, 1'b0, 3'd7, 20'h00007, 16'h0042, 4'b1001, 16'h4242},
    {1'b1, 1'b0, 1'b1, 3'd0, 20'h7FFF2, 16'h5AC3, 4'b0010, 16'h5AC3},
    {1'b1, 1'b0, 1'b0, 3'd1, 20'h00010, 16'h5AC3, 4'b0110, 16'h00C3},
    {1'b1, 1'b0, 1'b0, 3'd7, 20'h00011, 16'h5AC3, 4'b1010, 16'h005A},
    {1'b0, 1'b0, 1'b0, 3'd2, 20'h00AA0, 16'h9176, 4'b1110, 16'h0076}
  };

  function automatic logic [3:0] pinsNow();
    return {extPinA0Lb, extPinWrHi, extPinWrLo, extRdN};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runVec(input vec_t v);
    string pinReq;
    pinReq = v.mode ? "R6" : (v.wr ? "R4" : "R5");
    reqValid = 1'b1; reqWrite = v.wr; reqHalf = v.half; reqAddr = v.addr;
    reqWdata = v.data; cfgByteSelect = v.mode; cfgStrobeLen = v.len;
    memWord = v.data;
    tick();
    chk("R2", "setup cs", 32'(extCsN), 32'd0);
    chk("R2", "setup pins", 32'(pinsNow()), 32'hF);
    chk("R2", "setup busy", 32'(busy), 32'd1);
    chk("R3", "address", 32'(extAddr), 32'(v.addr[19:1]));
    reqValid = 1'b0;
    for (int k = 0; k <= int'(v.len); k++) begin
      tick();
      chk(pinReq, "strobe pins", 32'(pinsNow()), 32'(v.pins));
      chk("R2", "no done in strobe", 32'(done), 32'd0);
      if (v.wr) chk("R7", "write bus", 32'(extData), 32'(v.res));
    end
    tick();
    chk("R2", "hold done", 32'(done), 32'd1);
    chk("R2", "hold pins", 32'({extCsN, pinsNow()}), 32'h0F);
    if (!v.wr) chk("R8", "read data", 32'(rdData), 32'(v.res));
    tick();
    chk("R1", "idle after", 32'({busy, done, extCsN, pinsNow()}), 32'h1F);
    if (!v.wr) chk("R8", "read held", 32'(rdData), 32'(v.res));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "in reset", 32'({busy, done, extCsN, pinsNow()}), 32'h1F);
    rstN = 1'b1;
    tick();
    chk("R1", "after reset", 32'({busy, done, extCsN, pinsNow()}), 32'h1F);
    chk("R8", "reset rdData", 32'(rdData), 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R9 / R10: change fields and config mid access, keep reqValid held
    reqValid = 1'b1; reqWrite = 1'b1; reqHalf = 1'b1; reqAddr = 20'h00010;
    reqWdata = 16'h1111; cfgByteSelect = 1'b0; cfgStrobeLen = 3'd2;
    tick();
    chk("R9", "first setup addr", 32'(extAddr), 32'h8);
    reqAddr = 20'h00022; reqWdata = 16'h2222; cfgByteSelect = 1'b1;
    cfgStrobeLen = 3'd5;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10", "first pins keep style", 32'(pinsNow()), 32'h9);
      chk("R9", "first addr kept", 32'(extAddr), 32'h8);
      chk("R9", "first data kept", 32'(extData), 32'h1111);
    end
    tick();
    chk("R10", "first length kept", 32'(done), 32'd1);
    cfgStrobeLen = 3'd2;
    tick();
    chk("R9", "idle gap busy", 32'({busy, extCsN}), 32'h1);
    tick();
    chk("R9", "held request taken", 32'({busy, extCsN}), 32'h2);
    chk("R9", "second addr", 32'(extAddr), 32'h11);
    reqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6", "second pins", 32'(pinsNow()), 32'h1);
      chk("R7", "second data", 32'(extData), 32'h2222);
    end
    tick();
    chk("R2", "second done", 32'(done), 32'd1);
    tick();
    chk("R1", "final idle", 32'({busy, done, extCsN, pinsNow()}), 32'h1F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule